// File: doc/BRIEF.md
# Prime Exponent Extractor

This block recovers a single element from a number built as a product of prime powers. A request supplies a 32-bit value and a position index. The block selects the prime that belongs to that position and divides the value by it again and again. Each division that leaves no remainder adds one to a counter, and the first division that leaves a remainder ends the run. The counter is then the exponent of that prime in the value. The block also reports the part of the value that is left after all the exact divisions, so a later request can start from it. A built-in restoring divider produces one quotient bit per cycle.

A request is a one-cycle `start` pulse. It carries `numIn` and `idxIn`, and the block accepts it only while idle. When the work ends, `done` pulses for one cycle. `exponent`, `quotient` and `error` then keep their values until the next request is accepted. A request with a zero value, or with an index past the end of the prime table, is rejected at once with `error` set.

Top module: `pexp_extract`

## Requirements
- R1: Index k in 0..7 selects the k-th prime, counting from 2: 2, 3, 5, 7, 11, 13, 17, 19.
- R2: `exponent` is the number of exact divisions in a row by the selected prime, counted until the first division that leaves a nonzero remainder (for example 12 gives 2, 1, 0 at indices 0, 1, 2; 8 gives 3 at index 0; 6 gives 1 at indices 0 and 1).
- R3: Every exact division replaces the working value with its quotient and raises the count by one, so an exponent of up to 31 is reached (2^31 at index 0).
- R4: `quotient` equals `numIn` divided by prime^exponent, which is the working value after the last exact division.
- R5: An index of 8 or more sets `error` and `done` in the cycle after `start` is sampled, with `exponent` 0.
- R6: A `numIn` of 0 sets `error` and `done` in the cycle after `start` is sampled, with `exponent` 0, so no division is attempted.
- R7: `done` is high for exactly one cycle per accepted request. `exponent`, `quotient` and `error` hold their values until the next accepted request, and a valid request clears `error`.
- R8: A `start` that arrives while a request is in progress is ignored. It does not change the result and does not produce a second `done`.
- R9: After reset, `done`, `error`, `exponent` and `quotient` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, taken only when idle |
| numIn | input | 32 | Value to decode |
| idxIn | input | 4 | Prime position index |
| exponent | output | 6 | Count of exact divisions |
| quotient | output | 32 | Value left after the exact divisions |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Invalid request flag (zero value or index out of range) |

## Verification
The bench sweeps every table index against values built as prime powers times cofactors. A wrong prime table or an off-by-one in the division loop would then show up as an exponent that is off by one or a leftover value that is wrong. The largest exponent, 2^31 at index 0, catches a counter that is too narrow or a divider that loses the top bit. The value 1, all-ones and the boundary index 8 catch a design that divides zero forever or reads past its table. A start pulse in the middle of a request catches a design that reloads its operands or pulses `done` twice.

// File: rtl/pexp_pkg.sv
package pexp_pkg;
  localparam int DATA_W     = 32;
  localparam int IDX_W      = 4;
  localparam int NUM_PRIMES = 8;

  typedef struct packed {
    logic load;     // capture operands, clear count
    logic divInit;  // seed divider with working value
    logic divStep;  // one restoring division step
    logic accept;   // exact division: take quotient, count it
  } dpCtrl_t;

  // k-th prime, k = 0 gives 2; evaluated at elaboration only
  function automatic int nthPrime(input int k);
    int found;
    found = -1;
    for (int c = 2; c < 4096; c++) begin
      bit isP;
      isP = 1'b1;
      for (int d = 2; d * d <= c; d++) if (c % d == 0) isP = 1'b0;
      if (isP) begin
        found++;
        if (found == k) return c;
      end
    end
    return 2;
  endfunction
endpackage

// File: rtl/pexp_datapath.sv
module pexp_datapath
  import pexp_pkg::*;
#(
  parameter int DATA_W     = pexp_pkg::DATA_W,
  parameter int IDX_W      = pexp_pkg::IDX_W,
  parameter int NUM_PRIMES = pexp_pkg::NUM_PRIMES,
  localparam int CNT_W     = $clog2(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  input  logic [DATA_W-1:0] numIn,
  input  logic [IDX_W-1:0]  idxIn,
  output logic              inputBad,
  output logic              remZero,
  output logic [CNT_W-1:0]  exponent,
  output logic [DATA_W-1:0] quotient
);
  logic [DATA_W-1:0] primeTab [NUM_PRIMES];
  logic [DATA_W-1:0] primeSel;
  logic              idxOk;

  for (genvar g = 0; g < NUM_PRIMES; g++) begin : gPrime
    assign primeTab[g] = DATA_W'(nthPrime(g));
  end

  always_comb begin
    primeSel = '0;
    for (int g = 0; g < NUM_PRIMES; g++)
      if (int'(idxIn) == g) primeSel = primeTab[g];
  end

  assign idxOk    = int'(idxIn) < NUM_PRIMES;
  assign inputBad = !idxOk || (numIn == '0);

  logic [DATA_W-1:0] work, divisor, rem, quo;
  logic [CNT_W-1:0]  count;
  logic [DATA_W:0]   remShift, diff;
  logic              fits;

  assign remShift = {rem, quo[DATA_W-1]};
  assign diff     = remShift - {1'b0, divisor};
  assign fits     = !diff[DATA_W];
  assign remZero  = (rem == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      work    <= '0;
      count   <= '0;
      divisor <= '0;
      rem     <= '0;
      quo     <= '0;
    end else begin
      if (ctrl.load) begin
        work    <= numIn;
        count   <= '0;
        divisor <= primeSel;
      end
      if (ctrl.divInit) begin
        rem <= '0;
        quo <= work;
      end
      if (ctrl.divStep) begin
        rem <= fits ? diff[DATA_W-1:0] : remShift[DATA_W-1:0];
        quo <= {quo[DATA_W-2:0], fits};
      end
      if (ctrl.accept) begin
        work  <= quo;
        count <= count + 1'b1;
      end
    end
  end

  assign exponent = count;
  assign quotient = work;

  // R3: each exact division adds exactly one to the count
  a_r3_count_step: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.accept |=> count == $past(count) + 1'b1);
  // R3: taking a quotient always shrinks the working value
  a_r3_work_shrinks: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.accept |=> work < $past(work));
  // R2: restoring invariant, partial remainder stays below the prime
  a_r2_rem_bound: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.divStep && divisor != '0) |=> rem < divisor);
endmodule

// File: rtl/pexp_control.sv
module pexp_control
  import pexp_pkg::*;
#(
  parameter int DATA_W = pexp_pkg::DATA_W,
  localparam int STEP_W = $clog2(DATA_W) + 1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    inputBad,
  input  logic    remZero,
  output dpCtrl_t ctrl,
  output logic    done,
  output logic    error
);
  typedef enum logic [1:0] {IDLE, PREP, DIV, CHECK} state_t;
  state_t            state;
  logic [STEP_W-1:0] stepCnt;
  logic              doneReg, errReg;

  always_comb begin
    ctrl         = '0;
    ctrl.load    = (state == IDLE) && start;
    ctrl.divInit = (state == PREP);
    ctrl.divStep = (state == DIV);
    ctrl.accept  = (state == CHECK) && remZero;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= IDLE;
      stepCnt <= '0;
      doneReg <= 1'b0;
      errReg  <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      unique case (state)
        IDLE: if (start) begin
          if (inputBad) begin
            doneReg <= 1'b1;
            errReg  <= 1'b1;
          end else begin
            errReg <= 1'b0;
            state  <= PREP;
          end
        end
        PREP: begin
          stepCnt <= '0;
          state   <= DIV;
        end
        DIV: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == STEP_W'(DATA_W - 1)) state <= CHECK;
        end
        CHECK: begin
          if (remZero) state <= PREP;
          else begin
            doneReg <= 1'b1;
            state   <= IDLE;
          end
        end
        default: state <= IDLE;
      endcase
    end
  end

  assign done  = doneReg;
  assign error = errReg;

  // R7: completion is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R5: a rejected request raises the error together with done
  a_r5_error_with_done: assert property (@(posedge clk) disable iff (!rstN)
    $rose(error) |-> done);
  // R8: while busy the error flag cannot move
  a_r8_busy_error_stable: assert property (@(posedge clk) disable iff (!rstN)
    (state != IDLE) |=> $stable(error));
  // R2: the divider finishes its full bit count before a check
  a_r2_full_division: assert property (@(posedge clk) disable iff (!rstN)
    (state == CHECK) |-> $past(state) == DIV);
endmodule

// File: rtl/pexp_extract.sv
module pexp_extract
  import pexp_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      start,
  input  logic [DATA_W-1:0]         numIn,
  input  logic [IDX_W-1:0]          idxIn,
  output logic [$clog2(DATA_W):0]   exponent,
  output logic [DATA_W-1:0]         quotient,
  output logic                      done,
  output logic                      error
);
  dpCtrl_t ctrl;
  logic    inputBad, remZero;

  pexp_control #(.DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .inputBad(inputBad),
    .remZero(remZero), .ctrl(ctrl), .done(done), .error(error)
  );

  pexp_datapath #(.DATA_W(DATA_W), .IDX_W(IDX_W), .NUM_PRIMES(NUM_PRIMES)) uDp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .numIn(numIn), .idxIn(idxIn),
    .inputBad(inputBad), .remZero(remZero), .exponent(exponent), .quotient(quotient)
  );
endmodule

// File: tb/sim_pexp_extract.sv
module sim_pexp_extract;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] numIn = '0;
  logic [3:0]  idxIn = '0;
  logic [5:0]  exponent;
  logic [31:0] quotient;
  logic        done, error;
  int          nRun = 0, nFail = 0;
  int          cycles = 0;
  bit          finished = 0;

  always #4 clk = ~clk;  // 125 MHz
  always @(posedge clk) cycles++;

  pexp_extract u0 (.clk(clk), .rstN(rstN), .start(start), .numIn(numIn),
    .idxIn(idxIn), .exponent(exponent), .quotient(quotient), .done(done), .error(error));

  int primes[8] = '{2, 3, 5, 7, 11, 13, 17, 19};

  task automatic check(input string req, input longint act, input longint exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitDone(output bit ok);
    ok = 0;
    for (int c = 0; c < 2000; c++) begin
      @(negedge clk);
      if (done) begin ok = 1; break; end
    end
  endtask

  task automatic runOne(input logic [31:0] n, input int idx, input string req);
    bit ok;
    longint e, q, p;
    @(negedge clk);
    numIn = n; idxIn = 4'(idx); start = 1;
    @(negedge clk);
    start = 0;
    if (!done) waitDone(ok); else ok = 1;
    if (!ok) begin check({req, " done timeout"}, 0, 1); return; end
    if (n == 0 || idx >= 8) begin
      check({req, " error"}, error, 1);
      check({req, " exponent on error"}, exponent, 0);
    end else begin
      p = primes[idx]; q = n; e = 0;
      while (q % p == 0) begin q = q / p; e++; end
      check({req, " R2 exponent"}, exponent, e);
      check({req, " R4 quotient"}, quotient, q);
      check({req, " error clear"}, error, 0);
    end
    @(negedge clk);
    check("R7 done single pulse", done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++; nRun++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [5:0] hE; logic [31:0] hQ;
    bit ok;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 done", done, 0);
    check("R9 error", error, 0);
    check("R9 exponent", exponent, 0);
    check("R9 quotient", quotient, 0);
    rstN = 1;
    // R2 worked vectors
    runOne(12, 0, "R2 12@0"); runOne(12, 1, "R2 12@1"); runOne(12, 2, "R2 12@2");
    runOne(8, 0, "R2 8@0"); runOne(6, 0, "R2 6@0"); runOne(6, 1, "R2 6@1");
    // R1 sweep over every index with prime powers times cofactors
    for (int i = 0; i < 8; i++)
      for (int e = 0; e < 4; e++)
        foreach (primes[k]) begin
          longint v;
          v = 1;
          for (int j = 0; j < e; j++) v *= primes[i];
          v *= (k == i) ? 1 : primes[k];
          if (v < 64'h1_0000_0000) runOne(32'(v), i, "R1 sweep");
        end
    // R3 deepest exponent and divider edges
    runOne(32'h8000_0000, 0, "R3 2^31");
    runOne(32'hFFFF_FFFF, 0, "R3 all-ones@0");
    runOne(32'hFFFF_FFFF, 1, "R3 all-ones@1");
    runOne(32'd1162261467, 1, "R3 3^19");
    runOne(1, 7, "R2 one");
    // R5 / R6 rejects
    runOne(12, 8, "R5 idx8");
    runOne(12, 15, "R5 idx15");
    runOne(0, 0, "R6 zero");
    // R7 error cleared by valid request, outputs held
    runOne(40, 0, "R7 clear");
    hE = exponent; hQ = quotient;
    repeat (20) @(negedge clk);
    check("R7 exponent held", exponent, hE);
    check("R7 quotient held", quotient, hQ);
    // R8 start while busy ignored
    @(negedge clk);
    numIn = 8; idxIn = 0; start = 1;
    @(negedge clk);
    start = 0;
    repeat (5) @(negedge clk);
    numIn = 9; idxIn = 1; start = 1;
    @(negedge clk);
    start = 0; numIn = 0;
    waitDone(ok);
    check("R8 done", ok, 1);
    check("R8 exponent", exponent, 3);
    check("R8 quotient", quotient, 1);
    begin
      int extra;
      extra = 0;
      repeat (200) begin @(negedge clk); if (done) extra++; end
      check("R8 no second done", extra, 0);
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule